// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

This block turns single internal memory requests into timed external bus cycles for a small 8-bit controller core. Three cycle types exist: instruction fetch, data read and data write. Each one raises an address latch enable (`ale`) so that an external latch can capture the address, then pulls one of three active-low strobes (`psenN` for fetches, `rdN` for reads, `wrN` for writes). Data moves over two 8-bit lanes, each with an output value, an output enable and an input value. All timing counts periods of `clk`, which is the oscillator clock, and one bus state lasts two oscillator periods.

There are two lane layouts. In nonpage layout the low lane carries address bits 7:0 while `ale` is high and then carries data, and the high lane carries address bits 15:8. In page layout the low lane holds address bits 7:0 for the whole cycle, and the high lane carries address bits 15:8 under `ale` and then data. In page layout a fetch whose upper address byte matches the previous fetch skips the address phase. Fetches that hit back to back keep `psenN` low without a break. Extra wait states can be added to the `ale` phase and to the strobe phase. An optional ready input (`waitN`) can stretch a strobe in whole states, and a free-running half-rate clock (`wclk`) is available for external logic that times `waitN`.

Top module: `ebc_bus_seq`

## Requirements
- R1: While reset is held and in the first idle cycle after it, `ale` is 0, `psenN`, `rdN` and `wrN` are 1, `reqReady` is 1, `rspValid` is 0, `wclk` is 0 and neither lane output enable is set.
- R2: `reqKind` selects the cycle type: 0 is a fetch using `psenN`, 1 is a read using `rdN`, 2 is a write using `wrN`. In nonpage layout a full cycle holds `ale` high with address bits 7:0 on the low lane and bits 15:8 on the high lane. Then exactly one strobe goes low, and `ale` is never high while any strobe is low.
- R3: With `aleWait` at 0 the `ale` phase lasts 2 clock periods. With `aleWait` at 1 it lasts 4.
- R4: The strobe phase lasts 2*(1+`strobeWait`) clock periods for `strobeWait` from 0 to 3. This applies to fetches, reads and writes alike, including page-hit fetches.
- R5: Read and fetch data are sampled from the data lane (low lane in nonpage layout, high lane in page layout) on the clock edge that ends the strobe. `rspValid` pulses with the data on `rspData` in the cycle after that edge, and every `rspValid` follows a cycle with a strobe low.
- R6: During a write strobe the write data is driven with its output enable set, on the low lane in nonpage layout and on the high lane in page layout.
- R7: In page layout the low lane carries address bits 7:0 throughout the cycle, and both lanes are driven while `ale` is high.
- R8: In page layout a fetch whose address bits 15:8 equal those of the previous fetch has no `ale` phase and only the strobe phase.
- R9: When a page-hit fetch is presented before the previous fetch's strobe window ends, it is accepted at that window's last edge. `psenN` stays low across the boundary, and the previous fetch's `rspValid` appears in the first cycle of the new window.
- R10: With `rtWaitEn` at 1, a low `waitN` sampled on the last edge of a strobe state adds one more state (2 periods). This repeats until `waitN` is sampled high.
- R11: With `rtWaitEn` at 0, `waitN` has no effect on strobe length.
- R12: A data cycle, reset, or a return to nonpage layout forgets the previous fetch page, so the next fetch takes the `ale` phase.
- R13: With `wclkEn` at 1, `wclk` toggles on every clock edge. With it at 0, `wclk` is 0 from the next edge on.
- R14: Reads and writes always take the `ale` phase, even in page layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted at this edge when valid |
| reqAddr | input | 16 | Request address |
| reqWdata | input | 8 | Write data |
| reqKind | input | 2 | 0 fetch, 1 read, 2 write |
| rspValid | output | 1 | One-cycle completion pulse |
| rspData | output | 8 | Captured read or fetch data |
| pageMode | input | 1 | Page lane layout select |
| aleWait | input | 1 | Address phase wait states (0 or 1) |
| strobeWait | input | 2 | Strobe wait states (0 to 3) |
| rtWaitEn | input | 1 | Enables stretching by `waitN` |
| wclkEn | input | 1 | Enables `wclk` |
| waitN | input | 1 | Active-low ready from memory |
| wclk | output | 1 | Half-rate square wave |
| ale | output | 1 | Address latch enable |
| psenN | output | 1 | Fetch strobe, active low |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| loLaneOut | output | 8 | Low lane output value |
| loLaneOe | output | 1 | Low lane output enable |
| loLaneIn | input | 8 | Low lane input value |
| hiLaneOut | output | 8 | High lane output value |
| hiLaneOe | output | 1 | High lane output enable |
| hiLaneIn | input | 8 | High lane input value |

## Verification
The bound checker watches several properties on every cycle:
- `ale` and the strobes exclude each other, and at most one strobe is low at a time.
- Every completion follows a strobe, and a fetch strobe that is still low at a completion was already low in the cycle before.
- Every accepted read or write opens with `ale`, and `wclk` toggles or stays idle as enabled.

Phase lengths under each wait setting, page-hit detection and its forgetting, stretching by `waitN`, the lane layouts and the data returned can only be shown by the bench's scenarios. The bench does this with an external latch and memory model that decode the lanes as a real board would.

// File: rtl/ebc_pkg.sv
package ebc_pkg;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'd0,
    KIND_READ  = 2'd1,
    KIND_WRITE = 2'd2
  } cyc_kind_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic load;       // latch the request being accepted
    logic phaseAddr;  // address latch phase
    logic phaseStrb;  // strobe phase
    logic busy;       // any non-idle state
    logic capture;    // last edge of the strobe window
    logic pageSel;    // page lane layout for the current cycle
    logic isWrite;    // current cycle is a write
  } ebc_ctl_t;

endpackage

// File: rtl/ebc_ctrl.sv
module ebc_ctrl
  import ebc_pkg::*;
#(
  parameter int PAGE_W        = 8,
  parameter int ALE_WS_W      = 1,
  parameter int STB_WS_W      = 2,
  parameter int CLK_PER_STATE = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [PAGE_W-1:0]   reqPage,
  input  logic [1:0]          reqKind,
  input  logic                pageMode,
  input  logic [ALE_WS_W-1:0] aleWait,
  input  logic [STB_WS_W-1:0] strobeWait,
  input  logic                rtWaitEn,
  input  logic                waitN,
  output logic                ale,
  output logic                psenN,
  output logic                rdN,
  output logic                wrN,
  output logic                rspValid,
  output ebc_ctl_t            ctl
);

  localparam int MAX_ALE = CLK_PER_STATE * (2 ** ALE_WS_W);
  localparam int MAX_STB = CLK_PER_STATE * (2 ** STB_WS_W);
  localparam int MAX_CLK = (MAX_ALE > MAX_STB) ? MAX_ALE : MAX_STB;
  localparam int CNT_W   = $clog2(MAX_CLK);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_STRB, S_DONE} state_e;

  state_e            state;
  logic [CNT_W-1:0]  cnt;
  cyc_kind_e         kindQ;
  logic              pageQ;
  logic              pageValid;
  logic [PAGE_W-1:0] lastPage;
  logic              chainAck;

  logic [CNT_W-1:0] aleLoad, stbLoad;
  logic reqFetch, hitReq, winEnd, stretch, chainOk, accept, strb;

  always_comb begin
    aleLoad  = CNT_W'(CLK_PER_STATE * (int'(aleWait) + 1) - 1);
    stbLoad  = CNT_W'(CLK_PER_STATE * (int'(strobeWait) + 1) - 1);
    reqFetch = (reqKind == KIND_FETCH);
    hitReq   = reqFetch && pageMode && pageValid && (reqPage == lastPage);
    winEnd   = (state == S_STRB) && (cnt == '0);
    stretch  = winEnd && rtWaitEn && !waitN;
    chainOk  = winEnd && !stretch && pageQ && (kindQ == KIND_FETCH) &&
               reqValid && hitReq;
    accept   = ((state == S_IDLE) && reqValid) || chainOk;
    reqReady = (state == S_IDLE) || chainOk;
    strb     = (state == S_STRB);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      cnt       <= '0;
      kindQ     <= KIND_FETCH;
      pageQ     <= 1'b0;
      pageValid <= 1'b0;
      lastPage  <= '0;
      chainAck  <= 1'b0;
    end else begin
      chainAck <= chainOk;
      if (!pageMode) pageValid <= 1'b0;
      if (accept) begin
        kindQ     <= cyc_kind_e'(reqKind);
        pageQ     <= pageMode;
        pageValid <= pageMode && reqFetch;
        lastPage  <= reqPage;
      end
      case (state)
        S_IDLE: if (reqValid) begin
          if (hitReq) begin
            state <= S_STRB;
            cnt   <= stbLoad;
          end else begin
            state <= S_ADDR;
            cnt   <= aleLoad;
          end
        end
        S_ADDR: if (cnt == '0) begin
          state <= S_STRB;
          cnt   <= stbLoad;
        end else begin
          cnt <= cnt - 1'b1;
        end
        S_STRB: if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end else if (stretch) begin
          cnt <= CNT_W'(CLK_PER_STATE - 1);
        end else if (chainOk) begin
          cnt <= stbLoad;
        end else begin
          state <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign ale      = (state == S_ADDR);
  assign psenN    = !(strb && (kindQ == KIND_FETCH));
  assign wrN      = !(strb && (kindQ == KIND_WRITE));
  assign rdN      = !(strb && (kindQ != KIND_FETCH) && (kindQ != KIND_WRITE));
  assign rspValid = (state == S_DONE) || chainAck;

  always_comb begin
    ctl.load      = accept;
    ctl.phaseAddr = (state == S_ADDR);
    ctl.phaseStrb = strb;
    ctl.busy      = (state != S_IDLE);
    ctl.capture   = winEnd && !stretch;
    ctl.pageSel   = pageQ;
    ctl.isWrite   = (kindQ == KIND_WRITE);
  end

endmodule

// File: rtl/ebc_datapath.sv
module ebc_datapath
  import ebc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ebc_ctl_t          ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LANE_W-1:0] reqWdata,
  input  logic              wclkEn,
  input  logic [LANE_W-1:0] loLaneIn,
  input  logic [LANE_W-1:0] hiLaneIn,
  output logic [LANE_W-1:0] loLaneOut,
  output logic              loLaneOe,
  output logic [LANE_W-1:0] hiLaneOut,
  output logic              hiLaneOe,
  output logic [LANE_W-1:0] rspData,
  output logic              wclk
);

  logic [ADDR_W-1:0] addrQ;
  logic [LANE_W-1:0] wdataQ;
  logic [LANE_W-1:0] addrLo, addrHi;
  logic              wrPhase;

  assign addrLo  = addrQ[LANE_W-1:0];
  assign addrHi  = addrQ[ADDR_W-1 -: LANE_W];
  assign wrPhase = ctl.phaseStrb && ctl.isWrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      wdataQ  <= '0;
      rspData <= '0;
      wclk    <= 1'b0;
    end else begin
      wclk <= wclkEn ? !wclk : 1'b0;
      if (ctl.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (ctl.capture)
        rspData <= ctl.pageSel ? hiLaneIn : loLaneIn;
    end
  end

  always_comb begin
    if (ctl.pageSel) begin
      loLaneOut = addrLo;
      loLaneOe  = ctl.busy;
      hiLaneOut = ctl.phaseAddr ? addrHi : wdataQ;
      hiLaneOe  = ctl.phaseAddr || wrPhase;
    end else begin
      loLaneOut = ctl.phaseAddr ? addrLo : wdataQ;
      loLaneOe  = ctl.phaseAddr || wrPhase;
      hiLaneOut = addrHi;
      hiLaneOe  = ctl.busy;
    end
  end

endmodule

// File: rtl/ebc_bus_seq.sv
module ebc_bus_seq
  import ebc_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int LANE_W        = 8,
  parameter int ALE_WS_W      = 1,
  parameter int STB_WS_W      = 2,
  parameter int CLK_PER_STATE = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [LANE_W-1:0]   reqWdata,
  input  logic [1:0]          reqKind,
  output logic                rspValid,
  output logic [LANE_W-1:0]   rspData,
  input  logic                pageMode,
  input  logic [ALE_WS_W-1:0] aleWait,
  input  logic [STB_WS_W-1:0] strobeWait,
  input  logic                rtWaitEn,
  input  logic                wclkEn,
  input  logic                waitN,
  output logic                wclk,
  output logic                ale,
  output logic                psenN,
  output logic                rdN,
  output logic                wrN,
  output logic [LANE_W-1:0]   loLaneOut,
  output logic                loLaneOe,
  input  logic [LANE_W-1:0]   loLaneIn,
  output logic [LANE_W-1:0]   hiLaneOut,
  output logic                hiLaneOe,
  input  logic [LANE_W-1:0]   hiLaneIn
);

  localparam int PAGE_W = ADDR_W - LANE_W;

  ebc_ctl_t ctl;

  ebc_ctrl #(
    .PAGE_W(PAGE_W), .ALE_WS_W(ALE_WS_W), .STB_WS_W(STB_WS_W),
    .CLK_PER_STATE(CLK_PER_STATE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqPage(reqAddr[ADDR_W-1:LANE_W]), .reqKind(reqKind),
    .pageMode(pageMode), .aleWait(aleWait), .strobeWait(strobeWait),
    .rtWaitEn(rtWaitEn), .waitN(waitN), .ale(ale), .psenN(psenN),
    .rdN(rdN), .wrN(wrN), .rspValid(rspValid), .ctl(ctl)
  );

  ebc_datapath #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .wclkEn(wclkEn), .loLaneIn(loLaneIn),
    .hiLaneIn(hiLaneIn), .loLaneOut(loLaneOut), .loLaneOe(loLaneOe),
    .hiLaneOut(hiLaneOut), .hiLaneOe(hiLaneOe), .rspData(rspData),
    .wclk(wclk)
  );

endmodule

// File: rtl/ebc_bus_seq_chk.sv
module ebc_bus_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic       reqReady,
  input logic [1:0] reqKind,
  input logic       rspValid,
  input logic       wclkEn,
  input logic       wclk,
  input logic       ale,
  input logic       psenN,
  input logic       rdN,
  input logic       wrN,
  input logic       loLaneOe,
  input logic       hiLaneOe
);

  a_r2_phase_excl: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> (psenN && rdN && wrN));

  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $countones({psenN, rdN, wrN}) >= 2);

  a_r5_ack_after_strobe: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(!psenN || !rdN || !wrN));

  a_r9_chain_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !psenN) |-> $past(!psenN));

  a_r14_data_has_ale: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && (reqKind != 2'd0)) |=> ale);

  a_r7_ale_lanes: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> (loLaneOe && hiLaneOe));

  a_r13_wclk_run: assert property (@(posedge clk) disable iff (!rstN)
    wclkEn |=> (wclk != $past(wclk)));

  a_r13_wclk_off: assert property (@(posedge clk) disable iff (!rstN)
    !wclkEn |=> !wclk);

endmodule

bind ebc_bus_seq ebc_bus_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqKind(reqKind), .rspValid(rspValid), .wclkEn(wclkEn), .wclk(wclk),
  .ale(ale), .psenN(psenN), .rdN(rdN), .wrN(wrN),
  .loLaneOe(loLaneOe), .hiLaneOe(hiLaneOe)
);

// File: tb/tb_ebc_bus_seq.sv
module tb_ebc_bus_seq;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN, reqValid, reqReady, rspValid, pageMode, aleWait;
  logic        rtWaitEn, wclkEn, waitN, wclk, ale, psenN, rdN, wrN;
  logic        loLaneOe, hiLaneOe;
  logic [15:0] reqAddr;
  logic [7:0]  reqWdata, rspData, loLaneOut, loLaneIn, hiLaneOut, hiLaneIn;
  logic [1:0]  reqKind, strobeWait;

  ebc_bus_seq dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqKind(reqKind),
    .rspValid(rspValid), .rspData(rspData), .pageMode(pageMode),
    .aleWait(aleWait), .strobeWait(strobeWait), .rtWaitEn(rtWaitEn),
    .wclkEn(wclkEn), .waitN(waitN), .wclk(wclk), .ale(ale),
    .psenN(psenN), .rdN(rdN), .wrN(wrN), .loLaneOut(loLaneOut),
    .loLaneOe(loLaneOe), .loLaneIn(loLaneIn), .hiLaneOut(hiLaneOut),
    .hiLaneOe(hiLaneOe), .hiLaneIn(hiLaneIn)
  );

  typedef struct {
    int    kind;
    int    addr;
    int    data;
    int    aleClks;
    int    stbClks;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] memByte(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  // external address latch and memory model
  logic [7:0]  extLo = 8'h00, extHi = 8'h00;
  logic [15:0] addrSeen;
  assign addrSeen = pageMode ? {extHi, loLaneOut} : {hiLaneOut, extLo};
  assign loLaneIn = memByte(addrSeen);
  assign hiLaneIn = memByte(addrSeen);

  int waitHold = 0, stbRun = 0;
  assign waitN = !(waitHold != 0 && stbRun < waitHold);

  // monitor
  int aleCnt = 0, fCnt = 0, rCnt = 0, wCnt = 0, psenRises = 0, cyc = 0;
  logic [15:0] lastAddr = '0;
  logic [7:0]  lastWr = '0;
  logic        lastWrOe = 1'b0, prevPsen = 1'b1;

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (rspValid) begin
        if (q.size() == 0) begin
          check(1'b0, "R5 response without request", 1, 0);
        end else begin
          exp_t e;
          int kc;
          e = q.pop_front();
          kc = (e.kind == 0) ? fCnt : (e.kind == 1) ? rCnt : wCnt;
          check(aleCnt == e.aleClks, {e.tag, " ale length"}, aleCnt, e.aleClks);
          check(kc == e.stbClks && (fCnt + rCnt + wCnt) == e.stbClks,
                {e.tag, " strobe length"}, fCnt + rCnt + wCnt, e.stbClks);
          check(lastAddr == e.addr[15:0], {e.tag, " address"}, int'(lastAddr), e.addr);
          if (e.kind == 2)
            check(lastWr == e.data[7:0] && lastWrOe, {e.tag, " write lane"},
                  int'(lastWr), e.data);
          else
            check(rspData == e.data[7:0], {e.tag, " read data"}, int'(rspData), e.data);
        end
        aleCnt = 0; fCnt = 0; rCnt = 0; wCnt = 0;
      end
      if (ale) begin
        aleCnt++;
        if (pageMode) extHi = hiLaneOut;
        else extLo = loLaneOut;
      end
      if (!psenN) fCnt++;
      if (!rdN) rCnt++;
      if (!wrN) begin
        wCnt++;
        lastWr   = pageMode ? hiLaneOut : loLaneOut;
        lastWrOe = pageMode ? hiLaneOe : loLaneOe;
      end
      if (!psenN || !rdN || !wrN) begin
        lastAddr = addrSeen;
        stbRun++;
      end else begin
        stbRun = 0;
      end
      if (!prevPsen && psenN) psenRises++;
      prevPsen = psenN;
    end
    if (cyc > 150000) begin
      check(1'b0, "watchdog expired", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // driver
  bit       tbPageValid = 1'b0;
  bit [7:0] tbLastPage = '0;

  task automatic send(int kind, logic [15:0] addr, logic [7:0] wd, string tag, int stbOverride);
    exp_t e;
    bit hit;
    hit = pageMode && kind == 0 && tbPageValid && addr[15:8] == tbLastPage;
    tbPageValid = pageMode && kind == 0;
    tbLastPage  = addr[15:8];
    e.kind    = kind;
    e.addr    = int'(addr);
    e.data    = (kind == 2) ? int'(wd) : int'(memByte(addr));
    e.aleClks = hit ? 0 : 2 * (1 + int'(aleWait));
    e.stbClks = (stbOverride != 0) ? stbOverride : 2 * (1 + int'(strobeWait));
    e.tag     = tag;
    q.push_back(e);
    reqKind  = kind[1:0];
    reqAddr  = addr;
    reqWdata = wd;
    reqValid = 1'b1;
    #1;
    while (!reqReady) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitIdle();
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int r;
    logic a;
    rstN = 1'b0; reqValid = 1'b0; reqAddr = '0; reqWdata = '0; reqKind = '0;
    pageMode = 1'b0; aleWait = 1'b0; strobeWait = 2'd0; rtWaitEn = 1'b0; wclkEn = 1'b0;
    repeat (3) @(negedge clk);
    check(!ale && psenN && rdN && wrN, "R1 strobes in reset", int'({ale, psenN, rdN, wrN}), 7);
    rstN = 1'b1;
    @(negedge clk);
    check(!ale && psenN && rdN && wrN && !rspValid, "R1 idle outputs",
          int'({ale, psenN, rdN, wrN, rspValid}), 14);
    check(reqReady && !wclk && !loLaneOe && !hiLaneOe, "R1 ready and lanes",
          int'({reqReady, wclk, loLaneOe, hiLaneOe}), 8);

    // nonpage, no wait states
    send(0, 16'h1234, 8'h00, "R2 fetch", 0);
    send(1, 16'hABCD, 8'h00, "R2 R5 read", 0);
    send(2, 16'h4321, 8'h9C, "R2 R6 write", 0);
    waitIdle();

    // wait states
    aleWait = 1'b1; strobeWait = 2'd3;
    send(1, 16'h0F0F, 8'h00, "R3 R4 long read", 0);
    waitIdle();
    aleWait = 1'b0; strobeWait = 2'd1;
    send(2, 16'h2468, 8'h3C, "R4 write ws1", 0);
    waitIdle();

    // page layout, chained hits
    pageMode = 1'b1; strobeWait = 2'd0;
    @(negedge clk);
    r = psenRises;
    send(0, 16'h2210, 8'h00, "R7 R8 page miss", 0);
    send(0, 16'h2211, 8'h00, "R8 R9 hit one", 0);
    send(0, 16'h2212, 8'h00, "R9 hit two", 0);
    waitIdle();
    check(psenRises - r == 1, "R9 strobe held across hits", psenRises - r, 1);
    send(1, 16'h2213, 8'h00, "R14 page read", 0);
    send(0, 16'h2214, 8'h00, "R12 fetch after data", 0);
    send(2, 16'h3400, 8'h77, "R6 R14 page write", 0);
    waitIdle();

    // leaving page layout clears the page
    send(0, 16'h5000, 8'h00, "R7 page miss", 0);
    waitIdle();
    pageMode = 1'b0;
    repeat (2) @(negedge clk);
    pageMode = 1'b1;
    tbPageValid = 1'b0;
    send(0, 16'h5001, 8'h00, "R12 after layout exit", 0);
    waitIdle();
    strobeWait = 2'd1;
    send(0, 16'h5002, 8'h00, "R8 R4 idle hit ws1", 0);
    waitIdle();

    // reset clears the page
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    tbPageValid = 1'b0;
    strobeWait = 2'd0;
    @(negedge clk);
    send(0, 16'h5003, 8'h00, "R12 after reset", 0);
    waitIdle();

    // real-time wait
    pageMode = 1'b0; rtWaitEn = 1'b1; waitHold = 5;
    @(negedge clk);
    send(1, 16'h1357, 8'h00, "R10 stretched read", 6);
    waitIdle();
    rtWaitEn = 1'b0;
    send(1, 16'h1358, 8'h00, "R11 wait ignored", 0);
    waitIdle();
    waitHold = 0;

    // wait clock
    wclkEn = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      a = wclk;
      @(negedge clk);
      check(wclk != a, "R13 wclk toggles", int'(wclk), int'(!a));
    end
    wclkEn = 1'b0;
    repeat (2) @(negedge clk);
    check(!wclk, "R13 wclk idle", int'(wclk), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule